// File: doc/BRIEF.md
# Polysynchronous Stochastic Arithmetic Unit

This block turns four binary operand fractions into random bit streams, multiplies the first two with an AND gate, and forms the halved sum of the other two with a multiplexer. The multiplexer's select is a fifth stream with a fixed 1-in-2 probability. A value v on an OP_W-bit operand stands for the unipolar fraction v / 2^OP_W, which is the chance that a stream bit is 1. Each stream comes from its own 32-bit maximal-length shift-register generator with a distinct seed. On each of its step strobes, the generator compares a fresh random sample against the operand and emits 1 when the sample is smaller.

Every generator steps on an enable strobe from its own phase accumulator. This lets the streams run at unrelated, non-harmonic rates inside one clock domain, the way free-running local clocks would. Between strobes a generator holds its bit. Two window counters add the AND bit and the MUX bit on every system cycle over a fixed window of 2^WIN_LOG2 cycles. At the end of the window they return the ratio as a fixed-point fraction.

A run starts when an operand transfer is accepted on the valid/ready input. The result is offered on a valid/ready output. Back-pressure rules: the input is not ready while a run is in progress or while a result is still waiting. A waiting result stays on the output, unchanged, until the consumer takes it.

Top module: `stoch_poly_alu`

## Requirements
- R1: `in_ready` is high only when no run is active and no result is waiting. A transfer (`in_valid` and `in_ready` both high at a clock edge) latches the four operands and five rates, reloads every generator seed, clears all generator bits, accumulators and counters, and drops `in_ready` on the next cycle.
- R2: Each generator advances its 32-bit register (feedback taps 32, 22, 2, 1) by DRAWS shifts per strobe. It then outputs 1 when the top OP_W bits are below its level, and holds that bit until its next strobe. With both product operands at 1023 the product reads within 31 of 1022.
- R3: Each rate is an ACC_W-bit phase increment, and the strobe fires on the cycles where the accumulator addition carries out. An increment of 0 never strobes, so that stream stays 0. With the select rate at 0 the sum output equals operand C's stream.
- R4: `out_prod` reads within 31 (about 0.03 of full scale) of a·b/1024 for operands on several unrelated rate pairs.
- R5: The select stream uses level 512 (probability one half), and select 1 picks stream D while select 0 picks stream C. `out_sum` reads within 31 of (c+d)/2.
- R6: A zero operand A or B gives `out_prod` exactly 0. C and D both zero give `out_sum` exactly 0.
- R7: `out_valid` rises exactly 2^WIN_LOG2 clock edges after the accepting edge. Each result is the count of ones over that window, shifted right by WIN_LOG2−OP_W, on OP_W+1 bits where 1024 means 1.0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_prod` and `out_sum` hold steady and a new transfer is refused. One cycle after `out_valid` and `out_ready` are both high, `out_valid` is low and `in_ready` is high.
- R9: With all five rates equal, so that every generator steps together, the product and sum still meet the R4 and R5 bounds.
- R10: After reset `in_ready` is 1, `out_valid` is 0 and both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Unit idle and able to start a run |
| in_opa | input | OP_W | Product operand A fraction |
| in_opb | input | OP_W | Product operand B fraction |
| in_opc | input | OP_W | Sum operand C fraction (select 0) |
| in_opd | input | OP_W | Sum operand D fraction (select 1) |
| in_rate_a | input | ACC_W | Phase increment of generator A |
| in_rate_b | input | ACC_W | Phase increment of generator B |
| in_rate_c | input | ACC_W | Phase increment of generator C |
| in_rate_d | input | ACC_W | Phase increment of generator D |
| in_rate_sel | input | ACC_W | Phase increment of the select generator |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_prod | output | OP_W+1 | Measured product fraction |
| out_sum | output | OP_W+1 | Measured halved sum fraction |

## Verification
Mid-scale operands on rate pairs near 1 : 0.625 show that unaligned streams still multiply and average correctly. Several other non-harmonic rate sets, with asymmetric operands, separate a wrong operand routing or select polarity from a correct one. The all-equal-rate baseline and the full-scale operands expose correlation between streams and saturation at the top of the range. Zero operands and zero rates give exact results that any stray one or unexpected strobe would break. A refused transfer held during a run and during back-pressure shows that a second start cannot corrupt a result.

// File: rtl/stoch_pkg.sv
`timescale 1ns/1ps
package stoch_pkg;
  localparam int LFSR_W = 32;
  // feedback taps 32, 22, 2, 1 (maximal length)
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_t;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction

  // distinct non-zero seed per generator index
  function automatic logic [LFSR_W-1:0] seed_for(input int idx);
    logic [LFSR_W-1:0] mix;
    mix = LFSR_W'(idx + 1) * 32'h9E37_79B9;
    return mix ^ 32'h5EED_1234;
  endfunction
endpackage

// File: rtl/stoch_rate_gen.sv
`timescale 1ns/1ps
module stoch_rate_gen #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             strobe
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, inc};
  assign strobe  = run & acc_sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (run)   acc_q <= acc_sum[ACC_W-1:0];
  end
endmodule

// File: rtl/stoch_sng.sv
`timescale 1ns/1ps
module stoch_sng import stoch_pkg::*; #(
  parameter int                OP_W  = 10,
  parameter int                DRAWS = 10,
  parameter logic [LFSR_W-1:0] SEED  = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic            step,
  input  logic [OP_W-1:0] level,
  output logic            bit_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_adv;
  logic [OP_W-1:0]   sample;

  // DRAWS shifts per strobe so every compared bit is fresh
  always_comb begin
    state_adv = state_q;
    for (int k = 0; k < DRAWS; k++) state_adv = lfsr_step(state_adv);
  end

  assign sample = state_adv[LFSR_W-1 -: OP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
      bit_o   <= 1'b0;
    end else if (reload) begin
      state_q <= SEED;
      bit_o   <= 1'b0;
    end else if (step) begin
      state_q <= state_adv;
      bit_o   <= (sample < level);
    end
  end
endmodule

// File: rtl/stoch_window_cnt.sv
`timescale 1ns/1ps
module stoch_window_cnt #(
  parameter int CNT_W = 14,
  parameter int OUT_W = 11,
  parameter int SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_i,
  output logic [OUT_W-1:0] scaled_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] total;

  assign total    = count_q + CNT_W'(bit_i);
  assign scaled_o = OUT_W'(total >> SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (en)    count_q <= total;
  end
endmodule

// File: rtl/stoch_poly_alu.sv
`timescale 1ns/1ps
module stoch_poly_alu import stoch_pkg::*; #(
  parameter int OP_W     = 10,
  parameter int ACC_W    = 16,
  parameter int WIN_LOG2 = 13,
  parameter int DRAWS    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_opa,
  input  logic [OP_W-1:0]  in_opb,
  input  logic [OP_W-1:0]  in_opc,
  input  logic [OP_W-1:0]  in_opd,
  input  logic [ACC_W-1:0] in_rate_a,
  input  logic [ACC_W-1:0] in_rate_b,
  input  logic [ACC_W-1:0] in_rate_c,
  input  logic [ACC_W-1:0] in_rate_d,
  input  logic [ACC_W-1:0] in_rate_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W:0]    out_prod,
  output logic [OP_W:0]    out_sum
);
  localparam int NUM_OPS = 4;
  localparam int NUM_GEN = NUM_OPS + 1;
  localparam int SEL_IDX = NUM_OPS;
  localparam int CNT_W   = WIN_LOG2 + 1;
  localparam int RES_W   = OP_W + 1;
  localparam int SHIFT   = WIN_LOG2 - OP_W;
  localparam logic [OP_W-1:0] HALF_LEVEL = OP_W'(1) << (OP_W - 1);

  run_state_t state_q;
  logic [WIN_LOG2-1:0]             win_q;
  logic [NUM_OPS-1:0][OP_W-1:0]    op_q;
  logic [NUM_GEN-1:0][ACC_W-1:0]   rate_q;
  logic [NUM_GEN-1:0][OP_W-1:0]    level_vec;
  logic [NUM_GEN-1:0]              gen_step;
  logic [NUM_GEN-1:0]              gen_bits;
  logic [RES_W-1:0]                prod_scaled, sum_scaled;
  logic [RES_W-1:0]                prod_q, sum_q;
  logic accept, busy, last, prod_bit, sum_bit;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid & in_ready;
  assign busy      = (state_q == ST_RUN);
  assign last      = busy & (win_q == '1);
  assign out_prod  = prod_q;
  assign out_sum   = sum_q;

  always_comb begin
    for (int i = 0; i < NUM_GEN; i++) begin
      level_vec[i] = (i < NUM_OPS) ? op_q[i % NUM_OPS] : HALF_LEVEL;
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    stoch_rate_gen #(.ACC_W(ACC_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .run    (busy),
      .inc    (rate_q[g]),
      .strobe (gen_step[g])
    );
    stoch_sng #(.OP_W(OP_W), .DRAWS(DRAWS), .SEED(seed_for(g))) u_sng (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (accept),
      .step   (gen_step[g]),
      .level  (level_vec[g]),
      .bit_o  (gen_bits[g])
    );
  end

  assign prod_bit = gen_bits[0] & gen_bits[1];
  assign sum_bit  = gen_bits[SEL_IDX] ? gen_bits[3] : gen_bits[2];

  stoch_window_cnt #(.CNT_W(CNT_W), .OUT_W(RES_W), .SHIFT(SHIFT)) u_prod_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .en       (busy),
    .bit_i    (prod_bit),
    .scaled_o (prod_scaled)
  );

  stoch_window_cnt #(.CNT_W(CNT_W), .OUT_W(RES_W), .SHIFT(SHIFT)) u_sum_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .en       (busy),
    .bit_i    (sum_bit),
    .scaled_o (sum_scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      op_q    <= '0;
      rate_q  <= '0;
      prod_q  <= '0;
      sum_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          win_q   <= '0;
          op_q    <= {in_opd, in_opc, in_opb, in_opa};
          rate_q  <= {in_rate_sel, in_rate_d, in_rate_c, in_rate_b, in_rate_a};
        end
        ST_RUN: begin
          win_q <= win_q + WIN_LOG2'(1);
          if (last) begin
            state_q <= ST_DONE;
            prod_q  <= prod_scaled;
            sum_q   <= sum_scaled;
          end
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stoch_poly_alu_chk.sv
`timescale 1ns/1ps
module stoch_poly_alu_chk #(
  parameter int OP_W    = 10,
  parameter int ACC_W   = 16,
  parameter int NUM_OPS = 4,
  parameter int NUM_GEN = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [OP_W:0]                  out_prod,
  input logic [OP_W:0]                  out_sum,
  input logic [NUM_OPS-1:0][OP_W-1:0]   op_q,
  input logic [NUM_GEN-1:0][ACC_W-1:0]  rate_q,
  input logic [NUM_GEN-1:0]             gen_step,
  input logic [NUM_GEN-1:0]             gen_bits
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid))
    else $error("start did not enter run");

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && !in_ready && $stable(out_prod) && $stable(out_sum)))
    else $error("result not held under back-pressure");

  p_take_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready))
    else $error("result not released");

  p_zero_prod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q[0] == '0 || op_q[1] == '0)) |-> (out_prod == '0))
    else $error("zero operand gave non-zero product");

  p_zero_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q[2] == '0 && op_q[3] == '0) |-> (out_sum == '0))
    else $error("zero operands gave non-zero sum");

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_bit
    p_zero_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q[g] == '0) |-> !gen_bits[g])
      else $error("stopped generator emitted a one");

    p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_step[g] && !(in_valid && in_ready)) |=> $stable(gen_bits[g]))
      else $error("generator bit changed without a strobe");
  end
endmodule

bind stoch_poly_alu stoch_poly_alu_chk #(
  .OP_W(OP_W), .ACC_W(ACC_W), .NUM_OPS(NUM_OPS), .NUM_GEN(NUM_GEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod),
  .out_sum(out_sum), .op_q(op_q), .rate_q(rate_q),
  .gen_step(gen_step), .gen_bits(gen_bits)
);

// File: tb/stoch_poly_alu_bench.sv
`timescale 1ns/1ps
module stoch_poly_alu_bench;
  localparam int OP_W = 10, ACC_W = 16, WIN_LOG2 = 13;
  localparam int WIN = 1 << WIN_LOG2;
  localparam int TOL = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [OP_W-1:0]  opa = '0, opb = '0, opc = '0, opd = '0;
  logic [ACC_W-1:0] ra = '0, rb = '0, rc = '0, rd = '0, rs = '0;
  logic [OP_W:0]    out_prod, out_sum;
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  stoch_poly_alu u_stoch_poly_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opa(opa), .in_opb(opb), .in_opc(opc), .in_opd(opd),
    .in_rate_a(ra), .in_rate_b(rb), .in_rate_c(rc), .in_rate_d(rd),
    .in_rate_sel(rs), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_sum(out_sum)
  );

  task automatic check_eq(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(string req, int act, int exp);
    n_checks++;
    if (act > exp + TOL || act < exp - TOL) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, exp, TOL);
    end
  endtask

  task automatic start_run(int a, int b, int c, int d,
                           int r_a, int r_b, int r_c, int r_d, int r_s);
    @(negedge clk);
    opa = OP_W'(a); opb = OP_W'(b); opc = OP_W'(c); opd = OP_W'(d);
    ra = ACC_W'(r_a); rb = ACC_W'(r_b); rc = ACC_W'(r_c);
    rd = ACC_W'(r_d); rs = ACC_W'(r_s);
    in_valid = 1'b1;
    check_eq("R1 ready when idle", int'(in_ready), 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // R7: out_valid appears exactly WIN edges after the accepting edge
  task automatic wait_done();
    repeat (WIN - 1) @(posedge clk);
    @(negedge clk);
    check_eq("R7 not valid one edge early", int'(out_valid), 0);
    check_eq("R1 not ready during run", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check_eq("R7 valid at window end", int'(out_valid), 1);
  endtask

  task automatic hold_and_take(output int prod, output int sum);
    prod = int'(out_prod);
    sum  = int'(out_sum);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_eq("R8 result held under back-pressure",
               int'(out_valid && !in_ready && out_prod == prod && out_sum == sum), 1);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    check_eq("R8 released after take", int'(!out_valid && in_ready), 1);
  endtask

  task automatic run_case(int a, int b, int c, int d,
                          int r_a, int r_b, int r_c, int r_d, int r_s,
                          output int prod, output int sum);
    start_run(a, b, c, d, r_a, r_b, r_c, r_d, r_s);
    wait_done();
    hold_and_take(prod, sum);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R10 reset in_ready", int'(in_ready), 1);
    check_eq("R10 reset out_valid", int'(out_valid), 0);
    check_eq("R10 reset results", int'(out_prod) + int'(out_sum), 0);
  endtask

  task automatic t_half_inputs();
    int p, s;
    run_case(512, 512, 512, 512, 'hFFFF, 'hA000, 'hFFFF, 'hA000, 'hE666, p, s);
    check_near("R4 half times half", p, 256);
    check_near("R5 half plus half", s, 512);
  endtask

  task automatic t_rate_ratios();
    int p, s;
    run_case(300, 700, 100, 900, 'hE38E, 'h8000, 'h9249, 'hC000, 'hB6DB, p, s);
    check_near("R4 product ratio set 1", p, (300 * 700 + 512) / 1024);
    check_near("R5 sum ratio set 1", s, 500);
    run_case(900, 450, 850, 50, 'h8000, 'hF0F0, 'hD555, 'h9999, 'h8000, p, s);
    check_near("R4 product ratio set 2", p, (900 * 450 + 512) / 1024);
    check_near("R5 sum ratio set 2", s, 450);
  endtask

  task automatic t_baseline_equal();
    int p, s;
    run_case(600, 600, 200, 1000, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, p, s);
    check_near("R9 equal-rate product", p, (600 * 600 + 512) / 1024);
    check_near("R9 equal-rate sum", s, 600);
  endtask

  task automatic t_zero_operand();
    int p, s;
    run_case(0, 1023, 0, 0, 'hC000, 'hFFFF, 'hB000, 'hE000, 'h9000, p, s);
    check_eq("R6 zero operand product exact", p, 0);
    check_eq("R6 zero operands sum exact", s, 0);
  endtask

  task automatic t_zero_rate();
    int p, s;
    run_case(1023, 1023, 700, 100, 0, 'hFFFF, 'hFFFF, 'hFFFF, 0, p, s);
    check_eq("R3 stopped generator A gives zero product", p, 0);
    check_near("R3 stopped select leaves stream C", s, 700);
  endtask

  task automatic t_full_scale();
    int p, s;
    run_case(1023, 1023, 1023, 1023, 'hFFFF, 'hC000, 'hA000, 'hFFFF, 'hD000, p, s);
    check_near("R2 full-scale product", p, 1022);
    check_near("R5 full-scale sum", s, 1023);
  endtask

  // R1/R8: a second transfer offered during a run and under back-pressure is refused
  task automatic t_backpressure();
    int p, s;
    start_run(800, 800, 900, 300, 'hFFFF, 'hA000, 'hC000, 'hFFFF, 'hE000);
    opa = '0; opb = '0; opc = '0; opd = '0;
    in_valid = 1'b1;
    wait_done();
    hold_and_take(p, s);
    check_near("R1 refused transfer left product intact", p, 625);
    check_near("R1 refused transfer left sum intact", s, 600);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_half_inputs();
    t_rate_ratios();
    t_baseline_equal();
    t_zero_operand();
    t_zero_rate();
    t_full_scale();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule